// File: doc/BRIEF.md
# Nine-Port Pin Controller with Peripheral Hand-off

This block manages nine byte-wide groups of chip pins. Every pin is either a plain general-purpose pin or a pin handed to an on-chip peripheral. In general-purpose mode, software sets the pin's output level and direction through registers. In peripheral mode, the peripheral's own output value and output enable drive the pad. Pin input levels pass through a two-flop synchronizer. They are then forwarded to the peripherals and can be read back over a small register bus. The value read back depends on how the pin is configured at that moment.

Two reset inputs reach the block:
- The external reset restores the default pin configuration. Three ports take their default function from strap inputs, which are sampled while that reset is held.
- The watchdog reset clears only the bus and the synchronizer state. It keeps every configuration register, so pins continue to behave as they did before the watchdog fired.

The register bus carries a request channel and a read-response channel, both valid/ready:
- A request is taken on a cycle with `req_valid` and `req_ready` both high.
- A read returns its data on the response channel one cycle later.
- The response holds `rsp_valid` and `rsp_rdata` until the master raises `rsp_ready`.
- While a response is waiting, `req_ready` stays low, so reads back-pressure the requester.
- A write completes when it is taken and produces no response.

Top module: `gpio_mux_top`

## Requirements
- R1: On external reset, all output registers and all direction registers clear to 0. The function-select bits of ports 3 to 7 and of port 2 bit 7 become 0 (general-purpose). Port 2 bits 6..0 become 1 (peripheral).
- R2: While external reset is held, `strap[0]`, `strap[1]` and `strap[2]` are sampled into every function-select bit of ports 0, 1 and 8 respectively. A strap value of 1 means peripheral mode and 0 means general-purpose mode.
- R3: A watchdog reset leaves the output, direction and function-select registers unchanged and does not re-sample the straps. It drops any pending read response.
- R4: A general-purpose pin drives `pin_out` from its output-register bit. It drives `pin_oe` from its direction bit, where 1 means output.
- R5: A peripheral-mode pin drives `pin_out` from `per_out` and `pin_oe` from `per_oe`.
- R6: When a pin is an input, reading its pin-level register returns the synchronized input level. This applies in general-purpose mode, and in peripheral mode on ports 3 to 8.
- R7: When a pin is driving (`pin_oe` = 1), reading its pin-level register returns the level on `pin_out`.
- R8: A peripheral-mode pin of ports 0 to 2 whose `per_oe` is 0 reads back as 0.
- R9: The address is `{sel[1:0], port[3:0]}`. `sel` selects the register: 0 is pin level (read-only), 1 is output, 2 is direction, 3 is function-select. Writes to pin-level addresses are ignored. Reads of a port number 9 or above return 0, and writes to such a port change nothing.
- R10: Only reads produce a response, one cycle after the request is taken. `rsp_valid` and `rsp_rdata` hold until `rsp_ready`. `req_ready` is low while a response is pending.
- R11: `per_in` carries every pin's input level after two clock stages.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| ext_rst_n | input | 1 | External reset, active low, synchronous |
| wdt_rst_n | input | 1 | Watchdog reset, active low, synchronous |
| strap | input | 3 | Function straps for ports 0, 1 and 8 |
| req_valid | input | 1 | Bus request valid |
| req_ready | output | 1 | Bus request ready |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 6 | {register select, port number} |
| req_wdata | input | 8 | Write data |
| rsp_valid | output | 1 | Read response valid |
| rsp_ready | input | 1 | Read response ready |
| rsp_rdata | output | 8 | Read data |
| pin_in | input | 72 | Pad input levels, port p at bits 8p+7..8p |
| pin_out | output | 72 | Pad output levels |
| pin_oe | output | 72 | Pad output enables |
| per_out | input | 72 | Peripheral output values |
| per_oe | input | 72 | Peripheral output enables |
| per_in | output | 72 | Synchronized pad levels to peripherals |

## Verification
The bench builds the block with its default parameters: nine ports of eight pins, ports 0, 1 and 8 strapped, and port 2 as the mixed port. These defaults put all three port categories within reach:
- strapped ports, in both strap polarities;
- the port that mixes peripheral and general-purpose pins;
- plain ports.

The defaults also leave an unused port-number range (9 to 15) for probing out-of-range accesses. A four-bit port field against nine ports makes the address-ignore rules observable at the bus.

// File: rtl/gpio_mux_pkg.sv
package gpio_mux_pkg;
  typedef enum logic [1:0] {
    REG_PIN  = 2'd0,
    REG_OUT  = 2'd1,
    REG_DIR  = 2'd2,
    REG_FSEL = 2'd3
  } reg_sel_e;

  localparam int STRAP_N = 3;
endpackage

// File: rtl/gpio_sync2.sv
module gpio_sync2 #(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] d,
  output logic [N-1:0] q
);
  logic [N-1:0] stage1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stage1 <= '0;
      q      <= '0;
    end else begin
      stage1 <= d;
      q      <= stage1;
    end
  end
endmodule

// File: rtl/gpio_port.sv
module gpio_port #(
  parameter int          W         = 8,
  parameter logic [W-1:0] RST_FSEL = '0,
  parameter bit          USE_STRAP = 1'b0,
  parameter bit          ZERO_SEC  = 1'b0
) (
  input  logic         clk,
  input  logic         ext_rst_n,
  input  logic         strap_bit,
  input  logic         wr_out,
  input  logic         wr_dir,
  input  logic         wr_fsel,
  input  logic [W-1:0] wdata,
  input  logic [W-1:0] pin_sync,
  input  logic [W-1:0] per_out,
  input  logic [W-1:0] per_oe,
  output logic [W-1:0] po_q,
  output logic [W-1:0] dir_q,
  output logic [W-1:0] fsel_q,
  output logic [W-1:0] pin_out,
  output logic [W-1:0] pin_oe,
  output logic [W-1:0] rd_pin
);
  logic [W-1:0] in_mask;

  always_ff @(posedge clk) begin
    if (!ext_rst_n) begin
      po_q   <= '0;
      dir_q  <= '0;
      fsel_q <= USE_STRAP ? {W{strap_bit}} : RST_FSEL;
    end else begin
      if (wr_out)  po_q   <= wdata;
      if (wr_dir)  dir_q  <= wdata;
      if (wr_fsel) fsel_q <= wdata;
    end
  end

  assign pin_out = (fsel_q & per_out) | (~fsel_q & po_q);
  assign pin_oe  = (fsel_q & per_oe)  | (~fsel_q & dir_q);

  generate
    if (ZERO_SEC) begin : g_zero
      assign in_mask = ~fsel_q;
    end else begin : g_pass
      assign in_mask = '1;
    end
  endgenerate

  assign rd_pin = (pin_oe & pin_out) | (~pin_oe & pin_sync & in_mask);
endmodule

// File: rtl/gpio_regbus.sv
module gpio_regbus
  import gpio_mux_pkg::*;
#(
  parameter int NP = 9,
  parameter int W  = 8,
  parameter int PW = 4,
  parameter int AW = PW + 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_valid,
  input  logic            req_write,
  input  logic [AW-1:0]   req_addr,
  output logic            req_ready,
  output logic            rsp_valid,
  input  logic            rsp_ready,
  output logic [W-1:0]    rsp_rdata,
  input  logic [NP*W-1:0] rd_pin,
  input  logic [NP*W-1:0] rd_out,
  input  logic [NP*W-1:0] rd_dir,
  input  logic [NP*W-1:0] rd_fsel,
  output logic [NP-1:0]   wr_out,
  output logic [NP-1:0]   wr_dir,
  output logic [NP-1:0]   wr_fsel
);
  reg_sel_e      sel;
  logic [PW-1:0] idx;
  logic          take;
  logic [W-1:0]  rd_word;

  assign sel       = reg_sel_e'(req_addr[AW-1 -: 2]);
  assign idx       = req_addr[PW-1:0];
  assign req_ready = rst_n && !rsp_valid;
  assign take      = req_valid && req_ready;

  for (genvar p = 0; p < NP; p++) begin : g_dec
    assign wr_out[p]  = take && req_write && (sel == REG_OUT)  && (idx == PW'(p));
    assign wr_dir[p]  = take && req_write && (sel == REG_DIR)  && (idx == PW'(p));
    assign wr_fsel[p] = take && req_write && (sel == REG_FSEL) && (idx == PW'(p));
  end

  always_comb begin
    rd_word = '0;
    for (int p = 0; p < NP; p++) begin
      if (idx == PW'(p)) begin
        case (sel)
          REG_PIN:  rd_word = rd_pin[p*W +: W];
          REG_OUT:  rd_word = rd_out[p*W +: W];
          REG_DIR:  rd_word = rd_dir[p*W +: W];
          default:  rd_word = rd_fsel[p*W +: W];
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else if (take && !req_write) begin
      rsp_valid <= 1'b1;
      rsp_rdata <= rd_word;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/gpio_mux_top.sv
module gpio_mux_top
  import gpio_mux_pkg::*;
#(
  parameter int NUM_PORTS = 9,
  parameter int PORT_W    = 8,
  parameter int STRAP_A   = 0,
  parameter int STRAP_B   = 1,
  parameter int STRAP_C   = NUM_PORTS - 1,
  parameter int MIX_PORT  = 2,
  parameter int ZERO_RD_N = 3,
  parameter int PIDX_W    = $clog2(NUM_PORTS),
  parameter int ADDR_W    = PIDX_W + 2,
  parameter int BUS_W     = NUM_PORTS * PORT_W
) (
  input  logic               clk,
  input  logic               ext_rst_n,
  input  logic               wdt_rst_n,
  input  logic [STRAP_N-1:0] strap,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic               req_write,
  input  logic [ADDR_W-1:0]  req_addr,
  input  logic [PORT_W-1:0]  req_wdata,
  output logic               rsp_valid,
  input  logic               rsp_ready,
  output logic [PORT_W-1:0]  rsp_rdata,
  input  logic [BUS_W-1:0]   pin_in,
  output logic [BUS_W-1:0]   pin_out,
  output logic [BUS_W-1:0]   pin_oe,
  input  logic [BUS_W-1:0]   per_out,
  input  logic [BUS_W-1:0]   per_oe,
  output logic [BUS_W-1:0]   per_in
);
  logic                 soft_rst_n;
  logic [BUS_W-1:0]     pin_sync;
  logic [BUS_W-1:0]     rd_pin_flat;
  logic [BUS_W-1:0]     po_flat;
  logic [BUS_W-1:0]     dir_flat;
  logic [BUS_W-1:0]     fsel_flat;
  logic [NUM_PORTS-1:0] wr_out;
  logic [NUM_PORTS-1:0] wr_dir;
  logic [NUM_PORTS-1:0] wr_fsel;

  assign soft_rst_n = ext_rst_n && wdt_rst_n;
  assign per_in     = pin_sync;

  gpio_sync2 #(.N(BUS_W)) u_sync (
    .clk   (clk),
    .rst_n (soft_rst_n),
    .d     (pin_in),
    .q     (pin_sync)
  );

  gpio_regbus #(.NP(NUM_PORTS), .W(PORT_W), .PW(PIDX_W), .AW(ADDR_W)) u_bus (
    .clk       (clk),
    .rst_n     (soft_rst_n),
    .req_valid (req_valid),
    .req_write (req_write),
    .req_addr  (req_addr),
    .req_ready (req_ready),
    .rsp_valid (rsp_valid),
    .rsp_ready (rsp_ready),
    .rsp_rdata (rsp_rdata),
    .rd_pin    (rd_pin_flat),
    .rd_out    (po_flat),
    .rd_dir    (dir_flat),
    .rd_fsel   (fsel_flat),
    .wr_out    (wr_out),
    .wr_dir    (wr_dir),
    .wr_fsel   (wr_fsel)
  );

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    localparam bit HAS_STRAP = (p == STRAP_A) || (p == STRAP_B) || (p == STRAP_C);
    localparam int SIDX      = (p == STRAP_A) ? 0 : ((p == STRAP_B) ? 1 : 2);
    localparam logic [PORT_W-1:0] RST_FSEL =
      (p == MIX_PORT) ? {1'b0, {(PORT_W-1){1'b1}}} : '0;
    localparam bit ZERO_SEC  = (p < ZERO_RD_N);

    logic strap_bit;
    if (HAS_STRAP) begin : g_strap
      assign strap_bit = strap[SIDX];
    end else begin : g_nostrap
      assign strap_bit = 1'b0;
    end

    gpio_port #(
      .W         (PORT_W),
      .RST_FSEL  (RST_FSEL),
      .USE_STRAP (HAS_STRAP),
      .ZERO_SEC  (ZERO_SEC)
    ) u_port (
      .clk       (clk),
      .ext_rst_n (ext_rst_n),
      .strap_bit (strap_bit),
      .wr_out    (wr_out[p]),
      .wr_dir    (wr_dir[p]),
      .wr_fsel   (wr_fsel[p]),
      .wdata     (req_wdata),
      .pin_sync  (pin_sync[p*PORT_W +: PORT_W]),
      .per_out   (per_out[p*PORT_W +: PORT_W]),
      .per_oe    (per_oe[p*PORT_W +: PORT_W]),
      .po_q      (po_flat[p*PORT_W +: PORT_W]),
      .dir_q     (dir_flat[p*PORT_W +: PORT_W]),
      .fsel_q    (fsel_flat[p*PORT_W +: PORT_W]),
      .pin_out   (pin_out[p*PORT_W +: PORT_W]),
      .pin_oe    (pin_oe[p*PORT_W +: PORT_W]),
      .rd_pin    (rd_pin_flat[p*PORT_W +: PORT_W])
    );
  end
endmodule

// File: rtl/gpio_mux_chk.sv
module gpio_mux_chk #(
  parameter int NP  = 9,
  parameter int W   = 8,
  parameter int MIX = 2
) (
  input logic          clk,
  input logic          ext_rst_n,
  input logic          wdt_rst_n,
  input logic          req_ready,
  input logic          rsp_valid,
  input logic          rsp_ready,
  input logic [W-1:0]  rsp_rdata,
  input logic [NP*W-1:0] po_flat,
  input logic [NP*W-1:0] dir_flat,
  input logic [NP*W-1:0] fsel_flat,
  input logic [NP*W-1:0] pin_oe,
  input logic [NP*W-1:0] per_oe
);
  assert_rsp_hold_R10: assert property (@(posedge clk)
    disable iff (!ext_rst_n || !wdt_rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_rdata)));

  assert_busy_stall_R10: assert property (@(posedge clk)
    disable iff (!ext_rst_n || !wdt_rst_n)
    rsp_valid |-> !req_ready);

  assert_wdt_keep_R3: assert property (@(posedge clk)
    disable iff (!ext_rst_n)
    !wdt_rst_n |=> ($stable(po_flat) && $stable(dir_flat) && $stable(fsel_flat)));

  assert_ext_defaults_R1: assert property (@(posedge clk)
    disable iff (!wdt_rst_n)
    $rose(ext_rst_n) |-> (po_flat == '0 && dir_flat == '0 &&
                          fsel_flat[(NP-1)*W-1 : (MIX+1)*W] == '0));

  for (genvar i = 0; i < NP*W; i++) begin : g_pin
    assert_primary_in_R4: assert property (@(posedge clk)
      disable iff (!ext_rst_n)
      (!fsel_flat[i] && !dir_flat[i]) |-> !pin_oe[i]);

    assert_secondary_oe_R5: assert property (@(posedge clk)
      disable iff (!ext_rst_n)
      fsel_flat[i] |-> (pin_oe[i] == per_oe[i]));
  end
endmodule

bind gpio_mux_top gpio_mux_chk #(.NP(NUM_PORTS), .W(PORT_W), .MIX(MIX_PORT)) u_chk (
  .clk       (clk),
  .ext_rst_n (ext_rst_n),
  .wdt_rst_n (wdt_rst_n),
  .req_ready (req_ready),
  .rsp_valid (rsp_valid),
  .rsp_ready (rsp_ready),
  .rsp_rdata (rsp_rdata),
  .po_flat   (po_flat),
  .dir_flat  (dir_flat),
  .fsel_flat (fsel_flat),
  .pin_oe    (pin_oe),
  .per_oe    (per_oe)
);

// File: tb/gpio_mux_top_bench.sv
module gpio_mux_top_bench;
  localparam int NP = 9;
  localparam int W  = 8;
  localparam int AW = 6;
  localparam int BW = NP * W;

  logic          clk = 1'b0;
  logic          ext_rst_n = 1'b0;
  logic          wdt_rst_n = 1'b1;
  logic [2:0]    strap = 3'b101;
  logic          req_valid = 1'b0;
  logic          req_ready;
  logic          req_write = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [W-1:0]  req_wdata = '0;
  logic          rsp_valid;
  logic          rsp_ready = 1'b1;
  logic [W-1:0]  rsp_rdata;
  logic [BW-1:0] pin_in = '0;
  logic [BW-1:0] pin_out;
  logic [BW-1:0] pin_oe;
  logic [BW-1:0] per_out = '0;
  logic [BW-1:0] per_oe = '0;
  logic [BW-1:0] per_in;

  int checks = 0;
  int errors = 0;
  logic [W-1:0] exp_q[$];
  string        tag_q[$];

  always #4 clk = ~clk;

  gpio_mux_top u_gpio_mux_top (
    .clk (clk), .ext_rst_n (ext_rst_n), .wdt_rst_n (wdt_rst_n), .strap (strap),
    .req_valid (req_valid), .req_ready (req_ready), .req_write (req_write),
    .req_addr (req_addr), .req_wdata (req_wdata),
    .rsp_valid (rsp_valid), .rsp_ready (rsp_ready), .rsp_rdata (rsp_rdata),
    .pin_in (pin_in), .pin_out (pin_out), .pin_oe (pin_oe),
    .per_out (per_out), .per_oe (per_oe), .per_in (per_in)
  );

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] expv);
    checks++;
    if (act !== expv) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
    end
  endtask

  task automatic finish_sim();
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  // Monitor: pops expected read data as responses are handed over
  always @(negedge clk) begin
    #1;
    if (ext_rst_n && wdt_rst_n && rsp_valid && rsp_ready) begin
      if (exp_q.size() == 0) check("R10 unexpected response", 1, 0);
      else check(tag_q.pop_front(), rsp_rdata, exp_q.pop_front());
    end
  end

  task automatic bus_xfer(input logic wr, input logic [1:0] sel, input int port,
                          input logic [W-1:0] data, input logic [W-1:0] expv,
                          input string tag);
    @(negedge clk);
    req_valid = 1'b1;
    req_write = wr;
    req_addr  = {sel, 4'(port)};
    req_wdata = data;
    #1;
    while (!req_ready) begin
      @(negedge clk);
      #1;
    end
    if (!wr) begin
      exp_q.push_back(expv);
      tag_q.push_back(tag);
    end
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic wr(input logic [1:0] sel, input int port, input logic [W-1:0] data);
    bus_xfer(1'b1, sel, port, data, '0, "");
  endtask

  task automatic rd(input logic [1:0] sel, input int port, input logic [W-1:0] expv,
                    input string tag);
    bus_xfer(1'b0, sel, port, '0, expv, tag);
  endtask

  task automatic drain();
    for (int i = 0; i < 50 && exp_q.size() != 0; i++) @(negedge clk);
    check("R10 all responses delivered", exp_q.size(), 0);
  endtask

  task automatic ext_reset(input logic [2:0] s);
    @(negedge clk);
    ext_rst_n = 1'b0;
    strap = s;
    repeat (4) @(negedge clk);
    ext_rst_n = 1'b1;
    strap = ~s;
  endtask

  task automatic wait_cycles(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_sim();
  end

  initial begin
    logic [W-1:0] held;
    ext_reset(3'b101);
    wait_cycles(1);
    // R1 defaults
    check("R1 pin_oe after reset", pin_oe, '0);
    rd(2'd3, 2, 8'h7F, "R1 fsel port2");
    for (int p = 3; p <= 7; p++) rd(2'd3, p, 8'h00, "R1 fsel ports 3-7");
    rd(2'd2, 5, 8'h00, "R1 dir port5");
    rd(2'd1, 4, 8'h00, "R1 out port4");
    // R2 straps 101
    rd(2'd3, 0, 8'hFF, "R2 fsel port0 strap1");
    rd(2'd3, 1, 8'h00, "R2 fsel port1 strap0");
    rd(2'd3, 8, 8'hFF, "R2 fsel port8 strap1");
    drain();

    // R4 primary output and input
    wr(2'd2, 3, 8'hFF);
    wr(2'd1, 3, 8'hA5);
    #1;
    check("R4 pin_out port3", pin_out[3*W +: W], 8'hA5);
    check("R4 pin_oe port3", pin_oe[3*W +: W], 8'hFF);
    check("R4 pin_oe port4 input", pin_oe[4*W +: W], 8'h00);
    rd(2'd0, 3, 8'hA5, "R7 readback port3 output");

    // R6 / R11 primary input
    pin_in[4*W +: W] = 8'h3C;
    wait_cycles(3);
    check("R11 per_in port4", per_in[4*W +: W], 8'h3C);
    rd(2'd0, 4, 8'h3C, "R6 readback port4 input");

    // R5 mixed port 2
    per_out[2*W +: W] = 8'h55;
    per_oe[2*W +: W]  = 8'h0F;
    pin_in[2*W +: W]  = 8'hFF;
    wait_cycles(3);
    check("R5 pin_out port2", pin_out[2*W +: W], 8'h55);
    check("R5 pin_oe port2", pin_oe[2*W +: W], 8'h0F);
    rd(2'd0, 2, 8'h85, "R8 R7 readback port2 mixed");

    // R6 secondary input on port 8, R8 on port 0
    pin_in[8*W +: W] = 8'h96;
    pin_in[0 +: W]   = 8'hFF;
    wait_cycles(3);
    rd(2'd0, 8, 8'h96, "R6 readback port8 secondary input");
    rd(2'd0, 0, 8'h00, "R8 readback port0 secondary input");

    // R9 address rules
    wr(2'd0, 4, 8'h11);
    rd(2'd0, 4, 8'h3C, "R9 write to pin level ignored");
    wr(2'd1, 11, 8'h77);
    rd(2'd1, 9, 8'h00, "R9 out-of-range read");
    rd(2'd1, 3, 8'hA5, "R9 out-of-range write no effect");
    drain();

    // R10 back-pressure
    rsp_ready = 1'b0;
    rd(2'd1, 3, 8'hA5, "R10 held response data");
    #1;
    held = rsp_rdata;
    for (int i = 0; i < 3; i++) begin
      check("R10 rsp_valid held", rsp_valid, 1'b1);
      check("R10 req_ready low", req_ready, 1'b0);
      check("R10 rsp_rdata stable", rsp_rdata, held);
      @(negedge clk);
      #1;
    end
    rsp_ready = 1'b1;
    drain();
    wr(2'd1, 6, 8'h12);
    #1;
    check("R10 write gives no response", rsp_valid, 1'b0);

    // R3 watchdog keeps configuration
    wr(2'd3, 5, 8'hF0);
    wr(2'd2, 5, 8'h0F);
    wr(2'd1, 5, 8'h3C);
    rsp_ready = 1'b0;
    rd(2'd1, 5, 8'h3C, "R3 pending read");
    @(negedge clk);
    wdt_rst_n = 1'b0;
    strap = 3'b010;
    repeat (3) @(negedge clk);
    wdt_rst_n = 1'b1;
    #1;
    check("R3 pending response dropped", rsp_valid, 1'b0);
    exp_q.delete();
    tag_q.delete();
    rsp_ready = 1'b1;
    rd(2'd3, 5, 8'hF0, "R3 fsel kept");
    rd(2'd2, 5, 8'h0F, "R3 dir kept");
    rd(2'd1, 5, 8'h3C, "R3 out kept");
    rd(2'd3, 0, 8'hFF, "R3 strap not resampled port0");
    rd(2'd3, 1, 8'h00, "R3 strap not resampled port1");
    drain();

    // R1 / R2 second external reset with other straps
    ext_reset(3'b010);
    rd(2'd3, 0, 8'h00, "R2 fsel port0 strap0");
    rd(2'd3, 1, 8'hFF, "R2 fsel port1 strap1");
    rd(2'd3, 8, 8'h00, "R2 fsel port8 strap0");
    rd(2'd3, 5, 8'h00, "R1 fsel port5 restored");
    rd(2'd1, 5, 8'h00, "R1 out port5 cleared");
    drain();

    finish_sim();
  end
endmodule